// File: doc/BRIEF.md
# Packet Statistics Counter Engine

This block keeps a large array of packet counters in an on-chip memory. Other logic posts update requests, each a single 32-bit word carrying a counter index in its upper half and an increment in its lower half, into a small request FIFO. Counters outside the cached window are updated through a two-stage read-modify-write path on the memory. A result is forwarded from the write stage when the same index arrives twice in a row.

The highest-numbered counters form a cached window that is held in local registers. Updates to these counters add into the local copy in a single cycle and never touch the memory. A background sweep, started every `flush_period` cycles, visits every cached entry in turn. For each entry it captures and clears the local value in one cycle and adds the captured value into the matching memory word. Cached updates keep flowing during a sweep. Uncached updates wait while the sweep owns the memory read port.

A host read port returns counter values straight from the memory, one cycle after the request. After reset the block writes zero into every memory word before it accepts any request.

Top module: `stat_counter_engine`

## Requirements
- R1: A request word is split as index = bits [31:16] and increment = bits [15:0], and it is taken when `req_valid` and `req_ready` are both high on a rising edge. A request whose index is 1024 (the store depth) or larger is discarded and changes no counter.
- R2: After reset the block clears all 1024 memory words, one per cycle. `req_ready` stays low throughout this clear and rises within 1024 to 1028 cycles of reset release. Every counter then reads zero.
- R3: The request FIFO holds 8 words. `req_ready` is low whenever the FIFO is full, and no accepted request is lost while the FIFO is backed up.
- R4: A request to an uncached index (0 to 831) adds its increment to that memory word with a full 32-bit carry. The result is visible to the host within a few cycles.
- R5: Consecutive requests to the same uncached index, accepted on back-to-back cycles, are all counted.
- R6: Requests to indices 832 to 1023 accumulate in local registers. The memory word for such an index does not change until a sweep visits it.
- R7: While `flush_period` is non-zero, a sweep starts after that many idle cycles. The sweep adds every cached value into its memory word and clears the local copy. A period of zero disables sweeping.
- R8: Each cached increment reaches memory exactly once, including increments that arrive while a sweep is running. Later sweeps add nothing further.
- R9: `host_rd_en` with `host_rd_addr` returns the memory word on `host_rd_data`, with `host_rd_valid` high on the following cycle only. The value excludes any unflushed cached amount.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Update request present |
| req_data | input | 32 | Packed index (upper 16 bits) and increment (lower 16 bits) |
| req_ready | output | 1 | FIFO can take a request |
| flush_period | input | 16 | Idle cycles between sweeps; zero disables |
| host_rd_en | input | 1 | Host read strobe |
| host_rd_addr | input | 10 | Counter index to read |
| host_rd_data | output | 32 | Counter value from memory |
| host_rd_valid | output | 1 | `host_rd_data` is valid |

## Verification
The update path is tried with the following patterns:
- **Isolated single updates.** These expose the basic read-modify-write and the carry past 16 bits.
- **Back-to-back repeats to one index.** Interleaved pairs of indices tell a correct forward from a stale memory read.
- **An out-of-range index.** This separates discarding from wrapping.

Cached indices are first driven with sweeping off, which shows that the memory stays untouched. They are then driven with sweeping on, which shows the flush.

A long mixed burst of cached and uncached updates is issued during repeated sweeps. This fills the FIFO, which tests backpressure. Final totals are compared after later sweeps, which separates exactly-once accounting from lost or doubled increments.

// File: rtl/stat_pkg.sv
package stat_pkg;

    // Which operation claims the memory read port in a cycle.
    typedef enum logic [1:0] {
        ISSUE_IDLE  = 2'd0,
        ISSUE_REQ   = 2'd1,
        ISSUE_FLUSH = 2'd2
    } issue_e;

    localparam int DEF_IDX_W = 16;
    localparam int DEF_INC_W = 16;
    localparam int DEF_CNT_W = 32;

endpackage

// File: rtl/stat_req_fifo.sv
module stat_req_fifo #(
    parameter int W  = 32,
    parameter int AW = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         full,
    output logic         empty,
    output logic [W-1:0] head
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    logic [W-1:0] mem_q [DEPTH];

    assign full  = (st_q.cnt == (AW+1)'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign head  = mem_q[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (push) st_d.wp = st_q.wp + 1'b1;
        if (pop)  st_d.rp = st_q.rp + 1'b1;
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.wp] <= push_data;
    end

    // R3: occupancy never passes the depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= (AW+1)'(DEPTH));

    // R3: a full FIFO that is not drained stays full (nothing is overwritten)
    p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        full && !pop |=> full && st_q.rp == $past(st_q.rp));

endmodule

// File: rtl/stat_cache.sv
module stat_cache #(
    parameter int N     = 192,
    parameter int CW    = 8,
    parameter int CNT_W = 32,
    parameter int INC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic [CW-1:0]    acc_idx,
    input  logic [INC_W-1:0] acc_inc,
    input  logic             clr_en,
    input  logic [CW-1:0]    clr_idx,
    output logic [CNT_W-1:0] clr_val
);
    logic [CNT_W-1:0] val_q [N];
    logic [CNT_W-1:0] val_d [N];

    assign clr_val = (clr_idx < CW'(N)) ? val_q[clr_idx] : '0;

    for (genvar i = 0; i < N; i++) begin : g_entry
        logic hit_acc, hit_clr;
        logic [CNT_W-1:0] base;
        assign hit_acc = acc_en && (acc_idx == CW'(i));
        assign hit_clr = clr_en && (clr_idx == CW'(i));

        always_comb begin
            // Clear and capture happen in the same cycle; a coincident
            // increment lands on the cleared value so nothing is lost.
            base     = hit_clr ? '0 : val_q[i];
            val_d[i] = hit_acc ? base + CNT_W'(acc_inc) : base;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q[i] <= '0;
            else        val_q[i] <= val_d[i];
        end
    end

    // R8: a flushed entry without a coincident increment is zero afterwards
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en && (clr_idx < CW'(N)) && !(acc_en && acc_idx == clr_idx)
        |=> val_q[$past(clr_idx)] == '0);

endmodule

// File: rtl/stat_ram.sv
module stat_ram #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] ra_addr,
    output logic [DW-1:0] ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    // Read-first: a read in the same cycle as a write returns the old word.
    always_ff @(posedge clk) begin
        ra_data <= mem_q[ra_addr];
        rb_data <= mem_q[rb_addr];
        if (we) mem_q[waddr] <= wdata;
    end

endmodule

// File: rtl/stat_counter_engine.sv
module stat_counter_engine
    import stat_pkg::*;
#(
    parameter int IDX_W   = DEF_IDX_W,
    parameter int INC_W   = DEF_INC_W,
    parameter int CNT_W   = DEF_CNT_W,
    parameter int MEM_AW  = 10,
    parameter int CACHE_N = 192,
    parameter int FIFO_AW = 3,
    parameter int PER_W   = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [IDX_W+INC_W-1:0] req_data,
    output logic                   req_ready,
    input  logic [PER_W-1:0]       flush_period,
    input  logic                   host_rd_en,
    input  logic [MEM_AW-1:0]      host_rd_addr,
    output logic [CNT_W-1:0]       host_rd_data,
    output logic                   host_rd_valid
);
    localparam int REQ_W      = IDX_W + INC_W;
    localparam int DEPTH      = 1 << MEM_AW;
    localparam int CACHE_BASE = DEPTH - CACHE_N;
    localparam int CW         = (CACHE_N > 1) ? $clog2(CACHE_N) : 1;

    typedef struct packed {
        logic              valid;
        logic [MEM_AW-1:0] addr;
        logic [CNT_W-1:0]  val;
    } op_t;

    typedef struct packed {
        logic              init;
        logic [MEM_AW-1:0] init_idx;
        logic              sweep;
        logic [CW-1:0]     sweep_idx;
        logic [PER_W-1:0]  timer;
        op_t               s1;
        op_t               wb;
        logic              rd_valid;
    } state_t;

    state_t st_q, st_d;

    // FIFO wiring
    logic             fifo_full, fifo_empty, fifo_pop, fifo_push;
    logic [REQ_W-1:0] fifo_head;

    // Cache wiring
    logic             acc_en, clr_en;
    logic [CW-1:0]    acc_idx, clr_idx;
    logic [CNT_W-1:0] clr_val;

    // Memory wiring
    logic              mem_we;
    logic [MEM_AW-1:0] mem_waddr, ra_addr;
    logic [CNT_W-1:0]  mem_wdata, ra_data;

    // Decoded head request
    logic [IDX_W-1:0]  head_idx;
    logic [INC_W-1:0]  head_inc;
    logic [MEM_AW-1:0] head_addr;
    logic              head_in_range, head_cached;
    issue_e            issue;
    logic [CNT_W-1:0]  fwd_base, rmw_sum;

    assign req_ready = !fifo_full && !st_q.init;
    assign fifo_push = req_valid && req_ready;

    stat_req_fifo #(.W(REQ_W), .AW(FIFO_AW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (req_data),
        .pop       (fifo_pop),
        .full      (fifo_full),
        .empty     (fifo_empty),
        .head      (fifo_head)
    );

    stat_cache #(.N(CACHE_N), .CW(CW), .CNT_W(CNT_W), .INC_W(INC_W)) u_cache (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_en  (acc_en),
        .acc_idx (acc_idx),
        .acc_inc (head_inc),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .clr_val (clr_val)
    );

    stat_ram #(.AW(MEM_AW), .DW(CNT_W)) u_ram (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .ra_addr (ra_addr),
        .ra_data (ra_data),
        .rb_addr (host_rd_addr),
        .rb_data (host_rd_data)
    );

    assign host_rd_valid = st_q.rd_valid;

    always_comb begin
        st_d = st_q;

        // ---- decode the FIFO head ----
        head_idx      = fifo_head[REQ_W-1 -: IDX_W];
        head_inc      = fifo_head[INC_W-1:0];
        head_in_range = (head_idx < IDX_W'(DEPTH));
        head_addr     = head_idx[MEM_AW-1:0];
        head_cached   = head_in_range && (head_addr >= MEM_AW'(CACHE_BASE));

        // ---- read-port arbitration: the sweep owns the port while active ----
        issue = ISSUE_IDLE;
        if (st_q.sweep)
            issue = ISSUE_FLUSH;
        else if (!st_q.init && !fifo_empty && head_in_range && !head_cached)
            issue = ISSUE_REQ;

        // Cached and discarded requests never need the port.
        fifo_pop = !fifo_empty && !st_q.init
                   && (head_cached || !head_in_range || issue == ISSUE_REQ);

        acc_en  = fifo_pop && head_cached;
        acc_idx = CW'(head_addr - MEM_AW'(CACHE_BASE));
        clr_en  = (issue == ISSUE_FLUSH);
        clr_idx = st_q.sweep_idx;

        // ---- stage 1: issue a read and register the operation ----
        st_d.s1 = '0;
        case (issue)
            ISSUE_FLUSH: begin
                st_d.s1.valid = 1'b1;
                st_d.s1.addr  = MEM_AW'(CACHE_BASE) + MEM_AW'(st_q.sweep_idx);
                st_d.s1.val   = clr_val;
            end
            ISSUE_REQ: begin
                st_d.s1.valid = 1'b1;
                st_d.s1.addr  = head_addr;
                st_d.s1.val   = CNT_W'(head_inc);
            end
            default: ;
        endcase
        ra_addr = st_d.s1.addr;

        // ---- stage 2: add and write, forwarding the previous write ----
        fwd_base = (st_q.wb.valid && st_q.wb.addr == st_q.s1.addr)
                   ? st_q.wb.val : ra_data;
        rmw_sum  = fwd_base + st_q.s1.val;
        st_d.wb.valid = st_q.s1.valid;
        st_d.wb.addr  = st_q.s1.addr;
        st_d.wb.val   = rmw_sum;

        // ---- memory write port: clear at start-up, else stage 2 ----
        if (st_q.init) begin
            mem_we    = 1'b1;
            mem_waddr = st_q.init_idx;
            mem_wdata = '0;
        end else begin
            mem_we    = st_q.s1.valid;
            mem_waddr = st_q.s1.addr;
            mem_wdata = rmw_sum;
        end

        // ---- start-up clear sequencing ----
        if (st_q.init) begin
            st_d.init_idx = st_q.init_idx + 1'b1;
            if (st_q.init_idx == MEM_AW'(DEPTH - 1)) st_d.init = 1'b0;
        end

        // ---- sweep timer and sweep progress ----
        if (st_q.sweep) begin
            if (st_q.sweep_idx == CW'(CACHE_N - 1)) begin
                st_d.sweep     = 1'b0;
                st_d.sweep_idx = '0;
            end else begin
                st_d.sweep_idx = st_q.sweep_idx + 1'b1;
            end
        end else if (st_q.init || flush_period == '0) begin
            st_d.timer = '0;
        end else if (st_q.timer >= flush_period - 1'b1) begin
            st_d.timer     = '0;
            st_d.sweep     = 1'b1;
            st_d.sweep_idx = '0;
        end else begin
            st_d.timer = st_q.timer + 1'b1;
        end

        // ---- host read latency ----
        st_d.rd_valid = host_rd_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.init <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: no request is accepted while the start-up clear runs
    p_init_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.init |-> !fifo_push);

    // R4: every issued operation reaches the write stage the next cycle
    p_wb_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s1.valid |=> st_q.wb.valid && st_q.wb.addr == $past(st_q.s1.addr));

    // R7: a sweep steps through consecutive entries without gaps
    p_sweep_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sweep && st_q.sweep_idx != CW'(CACHE_N - 1)
        |=> st_q.sweep && st_q.sweep_idx == $past(st_q.sweep_idx) + 1'b1);

    // R6: a cached update never occupies the memory pipeline
    p_cached_local_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && !st_q.sweep |=> !st_q.s1.valid);

    // R9: a host read strobe is answered one cycle later
    p_host_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_en |=> host_rd_valid);

endmodule

// File: tb/tb_stat_counter_engine.sv
module tb_stat_counter_engine;
    localparam int DEPTH      = 1024;
    localparam int CACHE_N    = 192;
    localparam int CACHE_BASE = DEPTH - CACHE_N;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_data = '0;
    logic        req_ready;
    logic [15:0] flush_period = '0;
    logic        host_rd_en = 1'b0;
    logic [9:0]  host_rd_addr = '0;
    logic [31:0] host_rd_data;
    logic        host_rd_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit saw_full = 1'b0;

    // Scoreboard queues: expected value and requirement tag per read
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;   // 50 MHz

    stat_counter_engine dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_data      (req_data),
        .req_ready     (req_ready),
        .flush_period  (flush_period),
        .host_rd_en    (host_rd_en),
        .host_rd_addr  (host_rd_addr),
        .host_rd_data  (host_rd_data),
        .host_rd_valid (host_rd_valid)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Driver: one request, holding until accepted. Called just after a negedge.
    task automatic push(input logic [15:0] idx, input logic [15:0] inc);
        req_valid = 1'b1;
        req_data  = {idx, inc};
        while (!req_ready) begin
            saw_full = 1'b1;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Driver: host read, expected value into the scoreboard.
    task automatic host_read(input logic [9:0] addr, input logic [31:0] exp,
                             input string req);
        host_rd_en   = 1'b1;
        host_rd_addr = addr;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        @(negedge clk);
        host_rd_en = 1'b0;
    endtask

    // Monitor: compare each returned word with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && host_rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unrequested valid", {31'd0, host_rd_valid}, 32'd0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(host_rd_data == e, t, host_rd_data, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int wait_cycles;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: ready held low during start-up clear, then rises
        repeat (10) @(negedge clk);
        check(req_ready == 1'b0, "R2 ready during clear", {31'd0, req_ready}, 32'd0);
        wait_cycles = 10;
        while (!req_ready && wait_cycles < 2000) begin
            @(negedge clk);
            wait_cycles++;
        end
        check(wait_cycles >= 1024 && wait_cycles <= 1028, "R2 clear length",
              wait_cycles, 1024);
        host_read(10'd0,   32'd0, "R2 word 0 cleared");
        host_read(10'd517, 32'd0, "R2 word 517 cleared");
        host_read(10'd1023, 32'd0, "R2 word 1023 cleared");
        // R9: valid is a single-cycle pulse per strobe
        check(host_rd_valid == 1'b1, "R9 valid after read", {31'd0, host_rd_valid}, 32'd1);
        @(negedge clk);
        check(host_rd_valid == 1'b0, "R9 valid single cycle", {31'd0, host_rd_valid}, 32'd0);

        // R1 / R4: isolated updates, out-of-range discard, carry past 16 bits
        push(16'd5, 16'd3);
        push(16'h0405, 16'd7);      // index 1029: discarded, not wrapped to 5
        push(16'd100, 16'hFFFF);
        push(16'd100, 16'h0001);
        idle(8);
        host_read(10'd5,   32'd3,       "R1 discard of index >= 1024");
        host_read(10'd100, 32'h0001_0000, "R4 carry past 16 bits");
        host_read(10'd831, 32'd0,       "R4 neighbour untouched");

        // R5: back-to-back repeats and interleaved pairs
        for (int i = 1; i <= 6; i++) push(16'd20, 16'(i));
        for (int i = 0; i < 4; i++) begin
            push(16'd30, 16'd10);
            push(16'd31, 16'd100);
        end
        idle(8);
        host_read(10'd20, 32'd21,  "R5 six back-to-back");
        host_read(10'd30, 32'd40,  "R5 interleaved a");
        host_read(10'd31, 32'd400, "R5 interleaved b");

        // R6: cached indices with sweeping off leave memory unchanged
        push(16'd900, 16'd50);
        push(16'd1023, 16'd9);
        push(16'd832, 16'd4);
        idle(20);
        host_read(10'd900,  32'd0, "R6 memory excludes cached 900");
        host_read(10'd1023, 32'd0, "R6 memory excludes cached 1023");
        host_read(10'd831,  32'd0, "R6 last uncached stays zero");

        // R7: enable the sweep and wait for one to complete
        flush_period = 16'd50;
        idle(50 + CACHE_N + 20);
        host_read(10'd900,  32'd50, "R7 flushed 900");
        host_read(10'd1023, 32'd9,  "R7 flushed 1023");
        host_read(10'd832,  32'd4,  "R7 flushed first cached");

        // R3 / R8: long mixed burst across repeated sweeps
        saw_full = 1'b0;
        for (int i = 0; i < 200; i++) begin
            push(16'd950, 16'd1);
            push(16'd40, 16'd2);
        end
        idle(2 * (50 + CACHE_N) + 100);
        check(saw_full == 1'b1, "R3 ready low when full", {31'd0, saw_full}, 32'd1);
        host_read(10'd950, 32'd200, "R8 cached total during sweeps");
        host_read(10'd40,  32'd400, "R3 no uncached loss under backpressure");
        host_read(10'd900, 32'd50,  "R8 no double count 900");
        host_read(10'd1023, 32'd9,  "R8 no double count 1023");

        // R7: period zero stops further sweeps
        flush_period = 16'd0;
        idle(CACHE_N + 10);
        push(16'd1000, 16'd6);
        idle(400);
        host_read(10'd1000, 32'd0, "R7 period zero disables sweep");
        flush_period = 16'd40;
        idle(40 + CACHE_N + 20);
        host_read(10'd1000, 32'd6, "R7 sweep resumes");
        idle(4);

        check(exp_q.size() == 0, "R9 all reads answered", exp_q.size(), 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule